// File: doc/BRIEF.md
# SMBus Memory-Module EEPROM Write Guard

This block sits in the outgoing transaction path of an SMBus host controller. On every start of a transaction it inspects the 8-bit address byte, whose bit 0 is the read/write flag (1 = read, 0 = write). It decides whether the transaction may proceed, and it holds that decision until the stop condition. A protection bit guards one window of addresses, the range used by memory-module serial-presence-detect EEPROMs (A0h to AEh by default). While the bit is set, writes into that window are refused. Reads into the window, and any traffic outside it, always pass.

The protection bit can be written only once after reset, and firmware may write it at any time. A refused write raises a one-cycle abort to the transaction engine before any data byte goes out, and the engine then issues a stop. The refusal also sets a sticky error flag, which software clears by writing 1.

Top module: `smb_spd_wr_guard`

## Requirements
- R1: While the protection bit is 0, every transaction start yields allow_o = 1 and abort_o = 0 in the next cycle, for any address byte.
- R2: While the protection bit is 1, a start whose address byte lies in WIN_LO..WIN_HI (default A0h..AEh) with bit 0 = 0 yields allow_o = 0, abort_o = 1 and err_o = 1 in the next cycle.
- R3: A start whose address byte lies outside WIN_LO..WIN_HI (for example, upper nibble not Ah) is allowed, whatever bit 0 and the protection bit are.
- R4: A start with bit 0 = 1 (read) is always allowed, including A1h and AFh with the protection bit set.
- R5: The first protection write after reset (prot_wr_i = 1) loads prot_wdata_i and locks the bit. Later writes leave prot_o unchanged until reset.
- R6: A protection write takes effect for starts in later cycles. A start in the same cycle as the write is judged with the old value.
- R7: txn_active_o rises the cycle after a start, and allow_o holds its value while txn_active_o is 1. Both drop to 0 the cycle after txn_stop_i.
- R8: abort_o is a single-cycle pulse, asserted only in the cycle right after a denied start.
- R9: err_o is sticky. err_clr_i = 1 clears it in the next cycle, and a denial in the same cycle wins over the clear.
- R10: Reset clears the protection bit, its lock, err_o, txn_active_o, allow_o and abort_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txn_start_i | input | 1 | Start strobe; addr_byte_i is valid with it |
| addr_byte_i | input | 8 | Address byte, bit 0 = read/write flag |
| txn_stop_i | input | 1 | Stop condition of the current transaction |
| prot_wr_i | input | 1 | Protection register write strobe |
| prot_wdata_i | input | 1 | Protection bit write value |
| err_clr_i | input | 1 | Write-1-to-clear for the error flag |
| txn_active_o | output | 1 | A transaction is in progress |
| allow_o | output | 1 | Held decision: transaction may proceed |
| abort_o | output | 1 | One-cycle abort request for a denied write |
| prot_o | output | 1 | Current protection bit |
| err_o | output | 1 | Sticky denied-write error flag |

## Verification
The assertions assume that txn_start_i comes only while no transaction is active, or together with the stop of the previous one. They also assume that addr_byte_i is meaningful only while the start strobe is high. The scoreboard driver keeps to this: it raises a start only after the previous stop has been seen, and holds the strobe for exactly one cycle. Stop, clear and protection writes are driven on their own cycles. The only exceptions are the cases that deliberately place them in the same cycle as a start, which cover R6 and R9.

// File: rtl/smb_wrblk_pkg.sv
package smb_wrblk_pkg;
  typedef struct packed {
    logic allow;
    logic deny;
  } verdict_t;
endpackage

// File: rtl/smb_wrblk_lock.sv
module smb_wrblk_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  output logic prot_o
);
  logic prot_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_i && !lock_q) begin
      prot_q <= wdata_i;
      lock_q <= 1'b1;
    end
  end

  assign prot_o = prot_q;

  a_r5_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(prot_q));
  a_r5_first_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !lock_q) |=> (lock_q && prot_q == $past(wdata_i)));
endmodule

// File: rtl/smb_wrblk_classify.sv
module smb_wrblk_classify
  import smb_wrblk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 8'hA0,
  parameter logic [ADDR_W-1:0] WIN_HI = 8'hAE
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prot_i,
  output verdict_t          verdict_o
);
  logic in_win, is_write;

  assign in_win   = (addr_i >= WIN_LO) && (addr_i <= WIN_HI);
  assign is_write = ~addr_i[0];

  always_comb begin
    verdict_o.deny  = prot_i && in_win && is_write;
    verdict_o.allow = ~verdict_o.deny;
  end
endmodule

// File: rtl/smb_wrblk_hold.sv
module smb_wrblk_hold
  import smb_wrblk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     stop_i,
  input  verdict_t verdict_i,
  output logic     active_o,
  output logic     allow_o,
  output logic     abort_o
);
  logic active_q, allow_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      allow_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        allow_q  <= verdict_i.allow;
        abort_q  <= verdict_i.deny;
      end else if (stop_i) begin
        active_q <= 1'b0;
        allow_q  <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign allow_o  = allow_q;
  assign abort_o  = abort_q;

  a_r7_allow_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !start_i && !stop_i) |=> $stable(allow_q));
  a_r7_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!active_q && !allow_q));
  a_r8_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |=> !abort_q);
  a_r8_abort_denied_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> (active_q && !allow_q));
endmodule

// File: rtl/smb_wrblk_err.sv
module smb_wrblk_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (set_i)  err_q <= 1'b1;
    else if (clr_i)  err_q <= 1'b0;
  end

  assign err_o = err_q;

  a_r2_denial_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q);
  a_r9_clear_works: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_q);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);
endmodule

// File: rtl/smb_spd_wr_guard.sv
module smb_spd_wr_guard
  import smb_wrblk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 8'hA0,
  parameter logic [ADDR_W-1:0] WIN_HI = 8'hAE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txn_start_i,
  input  logic [ADDR_W-1:0] addr_byte_i,
  input  logic              txn_stop_i,
  input  logic              prot_wr_i,
  input  logic              prot_wdata_i,
  input  logic              err_clr_i,
  output logic              txn_active_o,
  output logic              allow_o,
  output logic              abort_o,
  output logic              prot_o,
  output logic              err_o
);
  verdict_t verdict;
  logic     prot;

  smb_wrblk_lock u_lock (
    .clk_i, .rst_ni,
    .wr_i(prot_wr_i), .wdata_i(prot_wdata_i), .prot_o(prot)
  );

  smb_wrblk_classify #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_cls (
    .addr_i(addr_byte_i), .prot_i(prot), .verdict_o(verdict)
  );

  smb_wrblk_hold u_hold (
    .clk_i, .rst_ni,
    .start_i(txn_start_i), .stop_i(txn_stop_i), .verdict_i(verdict),
    .active_o(txn_active_o), .allow_o(allow_o), .abort_o(abort_o)
  );

  smb_wrblk_err u_err (
    .clk_i, .rst_ni,
    .set_i(txn_start_i && verdict.deny), .clr_i(err_clr_i), .err_o(err_o)
  );

  assign prot_o = prot;

  a_r1_unprotected_allows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_i && !prot_o) |=> (allow_o && !abort_o));
  a_r3_outside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_i && (addr_byte_i < WIN_LO || addr_byte_i > WIN_HI)) |=> allow_o);
  a_r4_reads_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_i && addr_byte_i[0]) |=> (allow_o && !abort_o));
  a_r2_protected_write_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_i && prot_o && !addr_byte_i[0] && addr_byte_i >= WIN_LO && addr_byte_i <= WIN_HI)
      |=> (!allow_o && abort_o && err_o));
endmodule

// File: tb/tb_smb_spd_wr_guard.sv
module tb_smb_spd_wr_guard;
  typedef struct {
    logic [7:0] addr;
    logic       allow;
    logic       err;
    string      req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, pw = 1'b0, pd = 1'b0, clr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic active, allow, abort, prot, err;

  int checks = 0, failures = 0;
  exp_t q[$];
  logic start_d = 1'b0;
  logic m_prot = 1'b0, m_lock = 1'b0, m_err = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smb_spd_wr_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(start), .addr_byte_i(addr),
    .txn_stop_i(stop), .prot_wr_i(pw), .prot_wdata_i(pd), .err_clr_i(clr),
    .txn_active_o(active), .allow_o(allow), .abort_o(abort), .prot_o(prot), .err_o(err)
  );

  task automatic chk(input string req, input logic act, input logic ex, input string what);
    checks++;
    if (act !== ex) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, ex);
    end
  endtask

  // monitor: compares the cycle after each sampled start
  always @(posedge clk) start_d <= start;
  always @(negedge clk) begin
    if (start_d && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, allow, e.allow, $sformatf("allow addr=%h", e.addr));
      chk(e.req, abort, ~e.allow, $sformatf("abort addr=%h", e.addr));
      chk(e.req, err, e.err, $sformatf("err addr=%h", e.addr));
      chk("R7", active, 1'b1, "active after start");
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_prot = 0; m_lock = 0; m_err = 0;
    @(negedge clk);
  endtask

  task automatic prot_write(input logic v);
    pw = 1'b1; pd = v;
    if (!m_lock) begin m_prot = v; m_lock = 1'b1; end
    @(negedge clk);
    pw = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_err();
    clr = 1'b1; m_err = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    chk("R9", err, 1'b0, "err after clear");
  endtask

  // driver: one full transaction, expectation pushed for the monitor
  task automatic txn(input logic [7:0] a, input string req,
                     input logic with_clr = 1'b0, input logic with_pw = 1'b0,
                     input logic pw_val = 1'b0);
    exp_t e;
    logic deny, exp_allow;
    deny = m_prot && (a >= 8'hA0) && (a <= 8'hAE) && !a[0];
    exp_allow = !deny;
    m_err = deny ? 1'b1 : (with_clr ? 1'b0 : m_err);
    e.addr = a; e.allow = exp_allow; e.err = m_err; e.req = req;
    q.push_back(e);
    start = 1'b1; addr = a; clr = with_clr;
    if (with_pw) begin
      pw = 1'b1; pd = pw_val;
      if (!m_lock) begin m_prot = pw_val; m_lock = 1'b1; end
    end
    @(negedge clk);
    start = 1'b0; clr = 1'b0; pw = 1'b0; addr = 8'h00;
    @(negedge clk);
    chk("R8", abort, 1'b0, "abort second cycle");
    chk("R7", allow, exp_allow, "allow held");
    chk("R7", active, 1'b1, "active held");
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R7", active, 1'b0, "active after stop");
    chk("R7", allow, 1'b0, "allow after stop");
    @(negedge clk);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R10", active, 1'b0, "active in reset");
    chk("R10", allow, 1'b0, "allow in reset");
    chk("R10", err, 1'b0, "err in reset");
    chk("R10", prot, 1'b0, "prot in reset");
    do_reset();
    // R1: unprotected, everything allowed
    txn(8'hA0, "R1"); txn(8'hAE, "R1"); txn(8'h50, "R1"); txn(8'hA1, "R1");
    // R5: first write loads and locks
    prot_write(1'b1);
    chk("R5", prot, 1'b1, "prot after first write");
    prot_write(1'b0);
    chk("R5", prot, 1'b1, "prot after second write");
    // R2: protected writes in window denied
    txn(8'hA0, "R2");
    clear_err();
    txn(8'hAE, "R2");
    txn(8'hA6, "R9");  // sticky across a second denial
    clear_err();
    // R3: outside window
    txn(8'hB0, "R3"); txn(8'h9E, "R3"); txn(8'h30, "R3"); txn(8'hB1, "R3");
    chk("R3", err, 1'b0, "err untouched by outside traffic");
    // R4: reads in window
    txn(8'hA1, "R4"); txn(8'hAF, "R4"); txn(8'hA5, "R4");
    chk("R4", err, 1'b0, "err untouched by reads");
    // R9: denial wins over same-cycle clear
    txn(8'hA4, "R9", 1'b1);
    chk("R9", err, 1'b1, "err after set+clear");
    clear_err();
    // R10: reset clears bit and lock
    do_reset();
    chk("R10", prot, 1'b0, "prot after reset");
    // R6: write in same cycle as start uses old value
    txn(8'hA0, "R6", 1'b0, 1'b1, 1'b1);
    chk("R6", prot, 1'b1, "prot after write with start");
    txn(8'hA0, "R6");
    clear_err();
    do_reset();
    prot_write(1'b0);
    chk("R10", prot, 1'b0, "lock taken with zero write");
    prot_write(1'b1);
    chk("R5", prot, 1'b0, "locked at zero");
    txn(8'hA2, "R1");
    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R7 scoreboard residue actual=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule